// File: doc/BRIEF.md
# Dual-Master Banked Memory Mapper

This block sits between two bus masters, a processor and a video fetch engine, and a 128 KB RAM. The RAM is split into a 64 KB main area and a 64 KB secondary area. Each master issues 16-bit logical addresses and says which master it is through a one-bit select. The mapper turns every logical address into a 17-bit physical address.

A fixed 16 KB window, logical 16'h4000 to 16'h7FFF, can be redirected to one of four 16 KB secondary banks. Everything outside the window always lands in main RAM. An 8-bit control register decides the redirection. Software reaches it through a small write/read port at I/O address 16'hD301. The register holds one active-low enable per master and a 2-bit bank index. Because the two enables are independent, a processor access and a video fetch to the same logical address can reach different physical RAM at the same time.

The translation is purely combinational from the register, the address and the master select, so it adds no wait states. Only the register itself is clocked.

Top module: `bank_mapper`

## Requirements
- R1: After reset the control register reads 8'hFF, and every window access from either master maps to main RAM.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 16'hD301 stores `cfg_wdata` at the next rising clock edge. Before that edge the readback still shows the old value. After it, reading 16'hD301 returns the stored byte.
- R3: A write to any address other than 16'hD301 leaves the control register unchanged.
- R4: A logical address below 16'h4000 or above 16'h7FFF maps to {1'b0, address} for both masters, whatever the register holds.
- R5: With register bits 5 and 4 both 1, window accesses from both masters map to {1'b0, address}.
- R6: With bit 4 at 0 and bit 5 at 1, processor window accesses (`is_video`=0) go to the secondary bank, while video window accesses stay in main RAM.
- R7: With bit 5 at 0 and bit 4 at 1, video window accesses (`is_video`=1) go to the secondary bank, while processor window accesses stay in main RAM.
- R8: With bits 5 and 4 both 0, window accesses from both masters go to the secondary bank, and neither master reaches main RAM in the window.
- R9: A secondary access maps to {1'b1, bank, address[13:0]}, where bank is {bit 3, bit 2} of the register. Rewriting only these bits moves the window to another bank.
- R10: The physical address follows a change of `log_addr` or `is_video` in the same cycle, without any clock edge.
- R11: `cfg_rdata` is 8'h00 whenever `cfg_addr` is not 16'hD301.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | I/O address of the register access |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback data (zero when the address misses) |
| log_addr | input | 16 | Logical address of the current access |
| is_video | input | 1 | 1 = video fetch engine, 0 = processor |
| phys_addr | output | 17 | Translated physical RAM address |

## Verification
The checker assumes that `cfg_we`, `cfg_addr` and `cfg_wdata` stay steady from one falling clock edge to the next, so that the value captured at a rising edge is the value it later compares with the readback. It also assumes that `log_addr` and `is_video` are settled when they are sampled. The bench therefore changes every input only just after a falling edge and holds it through the next rising edge. It never drives `cfg_we` while it is testing a translation. Each translation check is taken after the inputs have settled and before any clock edge, which makes the no-latency property observable at the ports.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

   // identifies the requesting bus master
   typedef enum logic {
      MST_CPU   = 1'b0,
      MST_VIDEO = 1'b1
   } master_e;

   localparam int unsigned NUM_MASTERS = 2;

   // fields pulled out of the control byte
   typedef struct packed {
      logic       cpu_dis;   // active-low processor enable (1 = off)
      logic       vid_dis;   // active-low video enable (1 = off)
      logic [1:0] bank;      // secondary bank index
   } ctrl_fields_t;

endpackage

// File: rtl/bmm_ctrl_reg.sv
module bmm_ctrl_reg #(
   parameter int unsigned         DATA_W        = 8,
   parameter int unsigned         ADDR_W        = 16,
   parameter logic [ADDR_W-1:0]   REG_ADDR      = 16'hD301,
   parameter logic [DATA_W-1:0]   RESET_VAL     = 8'hFF,
   parameter bit                  ZERO_ON_MISS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_q
);

   logic hit;
   assign hit = (addr == REG_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= RESET_VAL;
      end else if (we && hit) begin
         ctrl_q <= wdata;
      end
   end

   generate
      if (ZERO_ON_MISS) begin : g_rd_gated
         assign rdata = hit ? ctrl_q : '0;
      end else begin : g_rd_open
         assign rdata = ctrl_q;
      end
   endgenerate

endmodule

// File: rtl/bmm_window_det.sv
module bmm_window_det #(
   parameter int unsigned             ADDR_W   = 16,
   parameter logic [ADDR_W-1:0]       WIN_BASE = 16'h4000,
   parameter int unsigned             WIN_W    = 14
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win
);

   localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W + 1)'(2 ** WIN_W);

   logic [ADDR_W:0] addr_x;
   assign addr_x = {1'b0, addr};
   assign in_win = (addr_x >= {1'b0, WIN_BASE}) && (addr_x < WIN_END);

endmodule

// File: rtl/bmm_route.sv
module bmm_route
   import bmm_pkg::*;
#(
   parameter int unsigned NMST = NUM_MASTERS
) (
   input  logic            in_win,
   input  master_e         master,
   input  logic [NMST-1:0] dis_n,      // per-master active-low enable, 1 = off
   output logic            to_sec
);

   logic [NMST-1:0] sec_req;

   generate
      for (genvar m = 0; m < NMST; m++) begin : g_mst
         assign sec_req[m] = in_win && !dis_n[m];
      end
   endgenerate

   assign to_sec = sec_req[master];

endmodule

// File: rtl/bmm_xlate.sv
module bmm_xlate #(
   parameter int unsigned LADDR_W = 16,
   parameter int unsigned BANK_W  = 2,
   parameter int unsigned WIN_W   = 14
) (
   input  logic [LADDR_W-1:0] log_addr,
   input  logic [BANK_W-1:0]  bank,
   input  logic               to_sec,
   output logic [LADDR_W:0]   phys_addr
);

   logic [LADDR_W:0] main_pa;
   logic [LADDR_W:0] sec_pa;

   assign main_pa   = {1'b0, log_addr};
   assign sec_pa    = {1'b1, bank, log_addr[WIN_W-1:0]};
   assign phys_addr = to_sec ? sec_pa : main_pa;

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bmm_pkg::*;
#(
   parameter int unsigned              LADDR_W    = 16,
   parameter int unsigned              CTRL_W     = 8,
   parameter int unsigned              BANK_W     = 2,
   parameter int unsigned              WIN_W      = 14,
   parameter logic [LADDR_W-1:0]       WIN_BASE   = 16'h4000,
   parameter logic [LADDR_W-1:0]       CTRL_ADDR  = 16'hD301,
   parameter logic [CTRL_W-1:0]        CTRL_RST   = 8'hFF,
   parameter int unsigned              CPU_EN_BIT = 4,
   parameter int unsigned              VID_EN_BIT = 5,
   parameter int unsigned              BANK_LSB   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [15:0]        cfg_addr,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic [15:0]        log_addr,
   input  logic               is_video,
   output logic [16:0]        phys_addr
);

   localparam int unsigned PADDR_W = LADDR_W + 1;

   // elaboration-time parameter checks
   generate
      if (BANK_W + WIN_W != LADDR_W) begin : g_bad_split
         $error("bank bits plus window bits must equal logical width");
      end
      if (BANK_LSB + BANK_W > CTRL_W) begin : g_bad_bank
         $error("bank field exceeds control register");
      end
      if (CPU_EN_BIT >= CTRL_W || VID_EN_BIT >= CTRL_W || CPU_EN_BIT == VID_EN_BIT) begin : g_bad_en
         $error("enable bit positions invalid");
      end
      if (LADDR_W != 16 || CTRL_W != 8) begin : g_bad_port
         $error("port widths are fixed at 16/8");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   ctrl_fields_t      fld;
   logic              in_win;
   logic              to_sec;
   master_e           mst;

   bmm_ctrl_reg #(
      .DATA_W      (CTRL_W),
      .ADDR_W      (LADDR_W),
      .REG_ADDR    (CTRL_ADDR),
      .RESET_VAL   (CTRL_RST),
      .ZERO_ON_MISS(1'b1)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .ctrl_q(ctrl_q)
   );

   assign fld.cpu_dis = ctrl_q[CPU_EN_BIT];
   assign fld.vid_dis = ctrl_q[VID_EN_BIT];
   assign fld.bank    = ctrl_q[BANK_LSB +: BANK_W];
   assign mst         = is_video ? MST_VIDEO : MST_CPU;

   bmm_window_det #(
      .ADDR_W  (LADDR_W),
      .WIN_BASE(WIN_BASE),
      .WIN_W   (WIN_W)
   ) u_win (
      .addr  (log_addr),
      .in_win(in_win)
   );

   bmm_route #(
      .NMST(NUM_MASTERS)
   ) u_route (
      .in_win(in_win),
      .master(mst),
      .dis_n ({fld.vid_dis, fld.cpu_dis}),
      .to_sec(to_sec)
   );

   logic [PADDR_W-1:0] pa;

   bmm_xlate #(
      .LADDR_W(LADDR_W),
      .BANK_W (BANK_W),
      .WIN_W  (WIN_W)
   ) u_xl (
      .log_addr (log_addr),
      .bank     (fld.bank),
      .to_sec   (to_sec),
      .phys_addr(pa)
   );

   assign phys_addr = pa;

endmodule

// File: rtl/bmm_chk.sv
module bmm_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [15:0] cfg_addr,
   input logic [7:0]  cfg_wdata,
   input logic [7:0]  cfg_rdata,
   input logic [15:0] log_addr,
   input logic        is_video,
   input logic [16:0] phys_addr,
   input logic [7:0]  ctrl_q
);

   logic win;
   assign win = (log_addr >= 16'h4000) && (log_addr <= 16'h7FFF);

   // R2
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 16'hD301) |=> (ctrl_q == $past(cfg_wdata)));

   // R3
   wr_miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == 16'hD301) |=> $stable(ctrl_q));

   // R4
   outside_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win |-> (phys_addr == {1'b0, log_addr}));

   // R5
   compat_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win && ctrl_q[5] && ctrl_q[4]) |-> !phys_addr[16]);

   // R8
   both_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win && !ctrl_q[5] && !ctrl_q[4]) |-> phys_addr[16]);

   // R6
   video_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win && is_video && ctrl_q[5]) |-> !phys_addr[16]);

   // R9
   sec_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[16] |-> (phys_addr[15:14] == ctrl_q[3:2] && phys_addr[13:0] == log_addr[13:0]));

   // R11
   rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr != 16'hD301) |-> (cfg_rdata == 8'h00));

endmodule

bind bank_mapper bmm_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata),
   .log_addr (log_addr),
   .is_video (is_video),
   .phys_addr(phys_addr),
   .ctrl_q   (ctrl_q)
);

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 13;

   typedef struct packed {
      logic [7:0]  ctrl;
      logic        vid;
      logic [15:0] addr;
      logic [16:0] exp;
   } vec_t;

   // ctrl bit5 = video off, bit4 = cpu off, bits3:2 = bank
   localparam vec_t VEC [0:NVEC-1] = '{
      '{8'hFF, 1'b0, 16'h5000, 17'h05000},   // R5
      '{8'hFF, 1'b1, 16'h4000, 17'h04000},   // R5
      '{8'hEF, 1'b0, 16'h4123, 17'h1C123},   // R6
      '{8'hEF, 1'b1, 16'h4123, 17'h04123},   // R6
      '{8'hDF, 1'b1, 16'h7FFF, 17'h1FFFF},   // R7
      '{8'hDF, 1'b0, 16'h7FFF, 17'h07FFF},   // R7
      '{8'hC3, 1'b0, 16'h6000, 17'h12000},   // R8
      '{8'hC3, 1'b1, 16'h6000, 17'h12000},   // R8
      '{8'hC7, 1'b0, 16'h4000, 17'h14000},   // R9
      '{8'hCB, 1'b1, 16'h5ABC, 17'h19ABC},   // R9
      '{8'hC3, 1'b0, 16'h3FFF, 17'h03FFF},   // R4
      '{8'hC3, 1'b1, 16'h8000, 17'h08000},   // R4
      '{8'hC3, 1'b0, 16'hD301, 17'h0D301}    // R4
   };
   localparam string TAG [0:NVEC-1] = '{"R5","R5","R6","R6","R7","R7","R8","R8",
                                        "R9","R9","R4","R4","R4"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_addr = 16'h0000;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic [15:0] log_addr = 16'h0000;
   logic        is_video = 1'b0;
   logic [16:0] phys_addr;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_mapper u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .log_addr (log_addr),
      .is_video (is_video),
      .phys_addr(phys_addr)
   );

   task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = 16'hD301;
   endtask

   task automatic probe(input logic v, input logic [15:0] a);
      is_video = v; log_addr = a;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cfg_addr = 16'hD301; #1;
      chk("R1", {9'd0, cfg_rdata}, 17'h000FF);
      probe(1'b0, 16'h4800); chk("R1", phys_addr, 17'h04800);
      probe(1'b1, 16'h4800); chk("R1", phys_addr, 17'h04800);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         wr(16'hD301, VEC[i].ctrl);
         probe(VEC[i].vid, VEC[i].addr);
         chk(TAG[i], phys_addr, VEC[i].exp);
      end

      // R2 timing: old value visible before the edge, new one after
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 16'hD301; cfg_wdata = 8'h5A; #1;
      chk("R2", {9'd0, cfg_rdata}, 17'h000C3);
      @(negedge clk);
      cfg_we = 1'b0; #1;
      chk("R2", {9'd0, cfg_rdata}, 17'h0005A);

      // R3 write to a neighbour address is ignored
      wr(16'hD300, 8'h00);
      #1; chk("R3", {9'd0, cfg_rdata}, 17'h0005A);
      wr(16'hD302, 8'hFF);
      #1; chk("R3", {9'd0, cfg_rdata}, 17'h0005A);

      // R11 readback gated on address
      cfg_addr = 16'hD300; #1;
      chk("R11", {9'd0, cfg_rdata}, 17'h00000);
      cfg_addr = 16'hD301;

      // R10 same-cycle response: both enables on, bank 2 (8'hC8)
      wr(16'hD301, 8'hC8);
      probe(1'b0, 16'h4001); chk("R10", phys_addr, 17'h18001);
      probe(1'b0, 16'h8001); chk("R10", phys_addr, 17'h08001);
      probe(1'b1, 16'h7000); chk("R10", phys_addr, 17'h1B000);

      // R9 only bank bits rewritten: bank 1, enables unchanged
      wr(16'hD301, 8'hC4);
      probe(1'b1, 16'h7000); chk("R9", phys_addr, 17'h17000);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule